// File: doc/BRIEF.md
# Privileged Interrupt Mask Register

This block keeps the processor's 6-bit interrupt mask. A smaller mask value admits only interrupts of higher priority, so lowering the mask is a privileged act. The set-mask instruction and the software-interrupt instruction both drive one shared request port. Each request carries the proposed mask and the program counter of the instruction that issued it.

The top four bits of that program counter decide whether the write is allowed. Code in the highest region may write any value. Code in the region just below it may write values from 8 upward. All other code may write only values from 16 upward. A write that is allowed takes effect at the next clock edge. A write that is refused leaves the mask as it was and raises a one-cycle permission-fault interrupt request. A request that arrives while that fault pulse is high belongs to an instruction being trapped, so the block drops it.

Top module: `irq_mask_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the mask output is 0 and the fault output is 0.
- R2: When the PC bits [15:12] are 4'b1111, a request with any mask value (0 to 63) is accepted. The mask output equals the requested value after the next rising edge.
- R3: When the PC bits [15:12] are 4'b1110, a request with mask value 8 or greater is accepted, and a request with a value below 8 is refused.
- R4: For every other value of the PC bits [15:12], a request with mask value 16 or greater is accepted, and a request with a value below 16 is refused.
- R5: A refused request leaves the mask output unchanged.
- R6: A refused request drives the fault output high for exactly the one cycle that follows the edge at which the request was sampled.
- R7: An accepted request leaves the fault output low.
- R8: In cycles with no request, the mask holds its value and no fault is raised.
- R9: A request that is present while the fault output is high is ignored. The mask is unchanged and no further fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A mask-write request is present this cycle |
| req_mask | input | 6 | Proposed mask value |
| req_pc | input | 16 | Program counter of the requesting instruction |
| mask_out | output | 6 | Current interrupt mask |
| fault_irq | output | 1 | One-cycle permission-fault interrupt request |

## Verification
The hardest case to reach from the ports is a request that lands in the same cycle as the fault pulse. It needs a refused write followed at once by another write with no idle cycle between them. The bench sweeps all 16 PC regions against all 64 mask values. After every refused write it issues a second request on the very next cycle, choosing one that would otherwise be accepted. It then checks that the mask did not move and that the fault pulse did not repeat.

// File: rtl/irq_mask_guard.sv
module irq_mask_guard #(
  parameter int MASK_W      = 6,
  parameter int PC_W        = 16,
  parameter int REGION_W    = 4,
  parameter int MID_FLOOR   = 8,
  parameter int USER_FLOOR  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MASK_W-1:0] req_mask,
  input  logic [PC_W-1:0]   req_pc,
  output logic [MASK_W-1:0] mask_out,
  output logic              fault_irq
);

  localparam logic [REGION_W-1:0] TOP_REGION = '1;
  localparam logic [REGION_W-1:0] MID_REGION = TOP_REGION - 1'b1;
  localparam logic [MASK_W-1:0]   MID_MIN    = MASK_W'(MID_FLOOR);
  localparam logic [MASK_W-1:0]   USER_MIN   = MASK_W'(USER_FLOOR);

  logic [REGION_W-1:0] region;
  logic                permitted;
  logic                live;

  assign region    = req_pc[PC_W-1 -: REGION_W];
  assign permitted = (region == TOP_REGION) ||
                     (region == MID_REGION && req_mask >= MID_MIN) ||
                     (req_mask >= USER_MIN);
  assign live      = req_valid && !fault_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_out  <= '0;
      fault_irq <= 1'b0;
    end else begin
      fault_irq <= live && !permitted;
      if (live && permitted) mask_out <= req_mask;
    end
  end

endmodule

module irq_mask_guard_chk #(
  parameter int MASK_W = 6,
  parameter int PC_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [MASK_W-1:0] req_mask,
  input logic [PC_W-1:0]   req_pc,
  input logic [MASK_W-1:0] mask_out,
  input logic              fault_irq
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> mask_out == '0 && !fault_irq);

  assert_top_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fault_irq && req_pc[PC_W-1 -: 4] == 4'hF)
      |=> mask_out == $past(req_mask) && !fault_irq);

  assert_refused_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> $stable(mask_out));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |=> !fault_irq);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(mask_out) && !fault_irq);

  assert_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fault_irq) |=> $stable(mask_out) && !fault_irq);

endmodule

bind irq_mask_guard irq_mask_guard_chk #(.MASK_W(MASK_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/irq_mask_guard_test.sv
module irq_mask_guard_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [5:0] req_mask;
  logic [15:0] req_pc;
  logic [5:0] mask_out;
  logic       fault_irq;

  int tests = 0;
  int fails = 0;
  logic [5:0] model;
  bit done = 0;

  always #10 clk = ~clk;

  irq_mask_guard uut (.*);

  function automatic bit allowed(input logic [3:0] nib, input logic [5:0] v);
    return nib == 4'hF || (nib == 4'hE && v >= 6'd8) || v >= 6'd16;
  endfunction

  task automatic check(input string req, input logic [5:0] m, input logic f);
    tests++;
    if (mask_out !== m || fault_irq !== f) begin
      fails++;
      $display("FAIL %s: mask=%0d fault=%0b expected mask=%0d fault=%0b",
               req, mask_out, fault_irq, m, f);
    end
  endtask

  task automatic step(input logic v, input logic [5:0] m, input logic [15:0] pc);
    @(negedge clk);
    req_valid = v; req_mask = m; req_pc = pc;
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mask = '0; req_pc = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", 6'd0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1", 6'd0, 1'b0);
    model = '0;

    for (int nib = 0; nib < 16; nib++) begin
      for (int v = 0; v < 64; v++) begin
        logic [15:0] pc;
        logic [5:0]  val;
        bit ok;
        pc  = {4'(nib), 12'(v * 37 + nib)};
        val = 6'(v);
        ok  = allowed(4'(nib), val);
        step(1'b1, val, pc);
        if (ok) begin
          model = val;
          check(nib == 15 ? "R2" : (nib == 14 ? "R3" : "R4"), model, 1'b0);
          check("R7", model, 1'b0);
          step(1'b0, 6'd63, 16'hFFFF);
          check("R8", model, 1'b0);
        end else begin
          check(nib == 14 ? "R3" : "R4", model, 1'b1);
          check("R5", model, 1'b1);
          step(1'b1, 6'(63 - v), 16'hF000);
          check("R9", model, 1'b0);
          check("R6", model, 1'b0);
        end
      end
    end

    step(1'b1, 6'd5, 16'hF123); model = 6'd5;
    check("R2", model, 1'b0);
    repeat (4) begin
      step(1'b0, 6'd40, 16'h0000);
      check("R8", model, 1'b0);
    end
    step(1'b1, 6'd7, 16'hE000);
    check("R3", model, 1'b1);
    step(1'b0, 6'd0, 16'h0000);
    check("R6", model, 1'b0);
    step(1'b1, 6'd8, 16'hE000); model = 6'd8;
    check("R3", model, 1'b0);
    step(1'b1, 6'd15, 16'hDFFF);
    check("R4", model, 1'b1);
    step(1'b0, 6'd0, 16'h0000);
    check("R6", model, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule